// File: doc/BRIEF.md
# Tree pseudo-LRU replacement unit

This block holds the replacement history of a set-associative cache with four ways. Each set owns a three-bit binary tree. Every access that the cache controller reports for a set and way moves the tree bits toward that way. The controller can also present a set index and read back the way to replace, chosen by walking the tree away from recent use. One command returns every set to its initial state. The controller decides whether a replacement is needed at all, using its own valid bits. Tag matching and line storage sit elsewhere.

A parameter selects a direct-mapped build. That build keeps no state and always names way 0 as the victim. The victim is read combinationally from the stored bits of the addressed set. Touch and clear commands land on the rising clock edge and can be seen one cycle later. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `tree_plru_unit`

## Requirements
- R1: After reset every set holds tree bits 000, so the victim reported for every set index is way 0.
- R2: A touch of way 0 or way 1 sets the root bit (bit 0) to 1. For way 0 it sets bit 1 to 1, and for way 1 it sets bit 1 to 0. Bit 2 keeps its value.
- R3: A touch of way 2 or way 3 sets the root bit to 0. For way 2 it sets bit 2 to 1, and for way 3 it sets bit 2 to 0. Bit 1 keeps its value.
- R4: Starting from 000, touches of ways 0, 1, 2 and 3 in turn leave the bits 110, 100, 001 and 000, written as bit0 bit1 bit2. The victims after each of these touches are 2, 2, 0 and 0.
- R5: Victim selection works as follows. With the root at 0, the victim is way 0 if bit 1 is 0 and way 1 if bit 1 is 1. With the root at 1, the victim is way 2 if bit 2 is 0 and way 3 if bit 2 is 1. Way numbers are plain binary on the 2-bit victim port.
- R6: The victim output follows the victim set index within the same cycle. A touch changes the victim only after the next rising clock edge.
- R7: A clear command returns the bits of every set to 000 at the next rising edge.
- R8: When clear and touch are both asserted in one cycle, the clear takes effect and the touch is dropped.
- R9: A touch changes only the addressed set. With neither touch nor clear asserted, no state changes.
- R10: With the way count parameter set to 1, no state is kept and the victim is always way 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all_i | input | 1 | Clear the tree bits of all sets |
| touch_en_i | input | 1 | Record an access to a set and way |
| touch_set_i | input | SET_W | Set index of the access |
| touch_way_i | input | WAY_W | Way number of the access |
| vic_set_i | input | SET_W | Set index for victim lookup |
| vic_way_o | output | WAY_W | Way chosen for replacement in the looked-up set |

## Verification
The victim is a pure function of the lookup index and the stored bits, so the bench changes the index and samples it a short time later in the same low phase of the clock. Touch and clear commands are driven at a falling edge and are stored at the following rising edge. Their effect is therefore sampled at the falling edge one half period later. The bench also samples once before that rising edge, to show that the old victim still holds. Reset is released at a falling edge, and checks start only after the synchronizer's two stages have cleared.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // Bit 0 is the root, bit 1 chooses within ways 0/1, bit 2 within ways 2/3.
  typedef struct packed {
    logic hi_pair;
    logic lo_pair;
    logic root;
  } tree_t;

  localparam tree_t TREE_CLEAR = '0;
endpackage

// File: rtl/plru_rst_sync.sv
module plru_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/plru_next.sv
module plru_next
  import plru_pkg::*;
(
  input  tree_t      cur_i,
  input  logic [1:0] way_i,
  output tree_t      nxt_o
);
  always_comb begin
    nxt_o      = cur_i;
    nxt_o.root = ~way_i[1];
    if (!way_i[1]) nxt_o.lo_pair = ~way_i[0];
    else           nxt_o.hi_pair = ~way_i[0];
  end
endmodule

// File: rtl/plru_pick.sv
module plru_pick
  import plru_pkg::*;
(
  input  tree_t      tree_i,
  output logic [1:0] way_o
);
  always_comb begin
    way_o[1] = tree_i.root;
    way_o[0] = tree_i.root ? tree_i.hi_pair : tree_i.lo_pair;
  end
endmodule

// File: rtl/plru_bank.sv
module plru_bank
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [1:0]       touch_way_i,
  input  logic [SET_W-1:0] rd_set_i,
  output tree_t            rd_tree_o
);
  tree_t [NUM_SETS-1:0] bits_q;
  tree_t [NUM_SETS-1:0] bits_d;
  tree_t                cur_t;
  tree_t                upd_t;
  logic                 wr_en;

  assign cur_t = bits_q[touch_set_i];

  plru_next u_next (
    .cur_i (cur_t),
    .way_i (touch_way_i),
    .nxt_o (upd_t)
  );

  assign wr_en = clr_i | touch_en_i;

  always_comb begin
    bits_d = bits_q;
    if (clr_i) begin
      for (int s = 0; s < NUM_SETS; s++) bits_d[s] = TREE_CLEAR;
    end else if (touch_en_i) begin
      bits_d[touch_set_i] = upd_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= '0;
    else if (wr_en) bits_q <= bits_d;
  end

  assign rd_tree_o = bits_q[rd_set_i];

  // R2: low-half touch points the root low, writes bit 1, keeps bit 2
  p_touch_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en_i && !clr_i && !touch_way_i[1]) |=>
      (bits_q[$past(touch_set_i)].root == 1'b1) &&
      (bits_q[$past(touch_set_i)].lo_pair == ~$past(touch_way_i[0])) &&
      (bits_q[$past(touch_set_i)].hi_pair == $past(cur_t.hi_pair)));

  // R3: high-half touch points the root high, writes bit 2, keeps bit 1
  p_touch_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en_i && !clr_i && touch_way_i[1]) |=>
      (bits_q[$past(touch_set_i)].root == 1'b0) &&
      (bits_q[$past(touch_set_i)].hi_pair == ~$past(touch_way_i[0])) &&
      (bits_q[$past(touch_set_i)].lo_pair == $past(cur_t.lo_pair)));

  // R9: without a command the stored state holds
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!touch_en_i && !clr_i) |=> $stable(bits_q));
endmodule

// File: rtl/tree_plru_unit.sv
module tree_plru_unit
  import plru_pkg::*;
#(
  parameter  int NUM_SETS = 16,
  parameter  int NUM_WAYS = 4,
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] vic_set_i,
  output logic [WAY_W-1:0] vic_way_o
);
  logic rst_sync_n;

  plru_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  generate
    if (NUM_WAYS == 1) begin : g_direct
      assign vic_way_o = '0;
    end else begin : g_tree
      tree_t      vic_tree;
      logic [1:0] pick_way;

      plru_bank #(
        .NUM_SETS (NUM_SETS),
        .SET_W    (SET_W)
      ) u_bank (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .clr_i       (clr_all_i),
        .touch_en_i  (touch_en_i),
        .touch_set_i (touch_set_i),
        .touch_way_i (touch_way_i[1:0]),
        .rd_set_i    (vic_set_i),
        .rd_tree_o   (vic_tree)
      );

      plru_pick u_pick (
        .tree_i (vic_tree),
        .way_o  (pick_way)
      );

      assign vic_way_o = pick_way;

      // R7: after a clear every set reports way 0
      p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        clr_all_i |=> (vic_way_o == '0));

      // R8: a touch in the clear cycle leaves no trace
      p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (clr_all_i && touch_en_i) |=> (vic_way_o == '0));
    end
  endgenerate
endmodule

// File: tb/tree_plru_unit_tb.sv
`timescale 1ns/1ps
module tree_plru_unit_tb;
  localparam int SETS = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_all;
  logic       touch_en;
  logic [3:0] touch_set;
  logic [1:0] touch_way;
  logic [3:0] vic_set;
  logic [1:0] vic_way;
  logic [0:0] dm_way_in;
  logic [0:0] dm_vic;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign dm_way_in = touch_way[0];

  tree_plru_unit #(.NUM_SETS(SETS), .NUM_WAYS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_all_i(clr_all), .touch_en_i(touch_en),
    .touch_set_i(touch_set), .touch_way_i(touch_way),
    .vic_set_i(vic_set), .vic_way_o(vic_way)
  );

  tree_plru_unit #(.NUM_SETS(SETS), .NUM_WAYS(1)) u_dut_dm (
    .clk(clk), .rst_n(rst_n), .clr_all_i(clr_all), .touch_en_i(touch_en),
    .touch_set_i(touch_set), .touch_way_i(dm_way_in),
    .vic_set_i(vic_set), .vic_way_o(dm_vic)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic peek(input int s, output int w);
    vic_set = 4'(s);
    #0.5;
    w = int'(vic_way);
  endtask

  task automatic touch(input int s, input int w);
    @(negedge clk);
    touch_en  = 1'b1;
    touch_set = 4'(s);
    touch_way = 2'(w);
    @(negedge clk);
    touch_en  = 1'b0;
  endtask

  task automatic t_reset();
    int w;
    for (int s = 0; s < SETS; s++) begin
      peek(s, w);
      check("R1 reset victim", w, 0);
    end
  endtask

  task automatic t_sequence();
    int w;
    touch(5, 0); peek(5, w); check("R4 after way0", w, 2);
    touch(5, 1); peek(5, w); check("R4 after way1", w, 2);
    touch(5, 2); peek(5, w); check("R4 after way2", w, 0);
    touch(5, 3); peek(5, w); check("R4 after way3", w, 0);
  endtask

  task automatic t_timing();
    int w;
    @(negedge clk);
    touch_en = 1'b1; touch_set = 4'd6; touch_way = 2'd0;
    peek(6, w); check("R6 old victim before edge", w, 0);
    @(negedge clk);
    touch_en = 1'b0;
    peek(6, w); check("R6 new victim after edge", w, 2);
  endtask

  task automatic t_decode();
    int w;
    touch(7, 0); touch(7, 2); peek(7, w); check("R5 state 011", w, 1);
    touch(8, 2); touch(8, 1); peek(8, w); check("R5 state 101", w, 3);
    touch(9, 2); touch(9, 0); peek(9, w); check("R2 bit2 kept", w, 3);
    touch(10, 0); touch(10, 3); peek(10, w); check("R3 bit1 kept", w, 1);
    touch(4, 1); touch(4, 3); peek(4, w); check("R3 way3 after way1", w, 0);
  endtask

  task automatic t_isolation();
    int w;
    peek(11, w); check("R9 untouched set", w, 0);
    peek(7, w);  check("R9 set 7 kept", w, 1);
    peek(8, w);  check("R9 set 8 kept", w, 3);
    repeat (3) @(negedge clk);
    peek(9, w);  check("R9 idle hold", w, 3);
  endtask

  task automatic t_clear();
    int w;
    @(negedge clk); clr_all = 1'b1;
    @(negedge clk); clr_all = 1'b0;
    peek(7, w); check("R7 clear set 7", w, 0);
    peek(8, w); check("R7 clear set 8", w, 0);
    peek(9, w); check("R7 clear set 9", w, 0);
    touch(7, 0); peek(7, w); check("R7 usable after clear", w, 2);
  endtask

  task automatic t_clear_wins();
    int w;
    touch(12, 3); touch(12, 0); peek(12, w); check("R8 setup", w, 2);
    @(negedge clk);
    clr_all = 1'b1; touch_en = 1'b1; touch_set = 4'd12; touch_way = 2'd1;
    @(negedge clk);
    clr_all = 1'b0; touch_en = 1'b0;
    peek(12, w); check("R8 clear beats touch", w, 0);
    peek(7, w);  check("R8 other set cleared", w, 0);
  endtask

  task automatic t_direct();
    touch(3, 1); vic_set = 4'd3; #0.5;
    check("R10 direct victim set 3", int'(dm_vic), 0);
    touch(0, 0); vic_set = 4'd0; #0.5;
    check("R10 direct victim set 0", int'(dm_vic), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_all = 1'b0; touch_en = 1'b0;
    touch_set = '0; touch_way = '0; vic_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sequence();
    t_timing();
    t_decode();
    t_isolation();
    t_clear();
    t_clear_wins();
    t_direct();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule